// File: doc/BRIEF.md
# Reset Sequencer and Clock Output Divider

This block produces the system reset outputs and two buffered copies of the crystal clock. A drive-IC reset is asserted whenever software clears a release bit or the host holds its reset line low. A CPU reset is asserted for a fixed number of clock cycles when the command decoder reports the soft-reset code 08h. A one-cycle interrupt to the CPU starts on the same cycle as that pulse. While the chip reset input is low, it passes straight through to the CPU reset. Both reset outputs are open drain. Each is modelled as an output-enable: 1 pulls the pad low and 0 lets it float.

The two clock outputs are chosen by configuration fields. The first output can be stopped, run at the input rate, or run at half rate. The second output can be stopped, run at the input rate, run at half rate in antiphase to the first, or run at 1/512 rate. Both outputs share one free-running 9-bit phase counter. A new mode is taken over only at a fixed counter phase where every candidate waveform of that output is low, so a mode change never produces a shortened pulse.

Top module: `rst_clk_unit`

## Requirements
- R1: After chip reset is released, the drive-IC reset is not asserted (release bit = 1), the CPU reset is not asserted, the interrupt is low, the first clock runs at the input rate (select 01) and the second clock is stopped (select 00).
- R2: `drv_rst_oe` is 1 whenever `host_rst_n` is 0 or the stored release bit is 0. It is 0 only when both are 1. A release-bit write takes effect in the cycle after the write strobe.
- R3: When `cmd_wr` is high with `cmd_byte` = 08h at a clock edge, `cpu_rst_oe` is 1 from the next cycle for exactly PULSE_CYCLES cycles. Any other code leaves it at 0.
- R4: `cpu_irq` is high for exactly the first cycle of each soft-reset pulse and low otherwise.
- R5: A soft-reset command that arrives during a pulse restarts the count, so the pulse ends PULSE_CYCLES cycles after the latest command.
- R6: While `rst_chip_n` is 0, `cpu_rst_oe` is 1 at once, with no clock needed. Reset also cancels any running pulse, so the output is 0 once reset is released.
- R7: First clock select `cfg_sel_a`: 00 and 11 hold the output low, 01 follows the input clock, 10 gives half rate.
- R8: Second clock select `cfg_sel_b`: 00 holds the output low, 01 follows the input clock, 10 gives half rate inverted relative to the first output's half rate, 11 gives 1/512 rate with a 50% duty cycle.
- R9: A new first-clock mode takes effect only in the low phase right after the phase counter wraps to zero. The second output changes mode one cycle later. The old waveform continues until then, which is at most 512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock |
| rst_chip_n | input | 1 | Chip reset, active low, asynchronous |
| host_rst_n | input | 1 | Host reset line, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_drv_release | input | 1 | Release bit for the drive-IC reset (0 asserts it) |
| cfg_sel_a | input | 2 | First clock output mode |
| cfg_sel_b | input | 2 | Second clock output mode |
| cmd_wr | input | 1 | Host command byte strobe |
| cmd_byte | input | 8 | Host command byte |
| drv_rst_oe | output | 1 | Drive-IC reset pull-down enable |
| cpu_rst_oe | output | 1 | CPU reset pull-down enable |
| cpu_irq | output | 1 | Interrupt marking the start of a soft-reset pulse |
| mck_a | output | 1 | First clock output |
| mck_b | output | 1 | Second clock output |

## Verification
A corrupted pulse counter shows up as a CPU reset that ends too early, too late or not at all. The length is measured cycle by cycle against PULSE_CYCLES, both for a single command and for a restart in mid-pulse. A wrong divider phase or mode register shows up within one period of the selected waveform, as a wrong level in the high or low half of the input clock. The switch test uses the 1/512 output as a phase reference. It checks that the first clock keeps its old mode right after the write and stops exactly at the wrap, so a switch made at any other phase is caught within 512 cycles.

// File: rtl/rst_clk_unit.sv
module rst_clk_unit #(
  parameter int          PULSE_CYCLES  = 33868,
  parameter int          DIV_LOG2      = 9,
  parameter logic [7:0]  SOFT_RST_CODE = 8'h08
) (
  input  logic       clk_xtal,
  input  logic       rst_chip_n,
  input  logic       host_rst_n,
  input  logic       cfg_we,
  input  logic       cfg_drv_release,
  input  logic [1:0] cfg_sel_a,
  input  logic [1:0] cfg_sel_b,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  output logic       drv_rst_oe,
  output logic       cpu_rst_oe,
  output logic       cpu_irq,
  output logic       mck_a,
  output logic       mck_b
);

  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [1:0] SEL_A_RST = 2'b01;
  localparam logic [1:0] SEL_B_RST = 2'b00;

  logic                release_q;
  logic [1:0]          sel_a_q, sel_b_q;
  logic [1:0]          mode_a, mode_b;
  logic [DIV_LOG2-1:0] div_cnt;
  logic [PW-1:0]       pulse_cnt;
  logic                irq_q;
  logic                soft_hit;

  always_ff @(posedge clk_xtal or negedge rst_chip_n) begin
    if (!rst_chip_n) begin
      release_q <= 1'b1;
      sel_a_q   <= SEL_A_RST;
      sel_b_q   <= SEL_B_RST;
    end else if (cfg_we) begin
      release_q <= cfg_drv_release;
      sel_a_q   <= cfg_sel_a;
      sel_b_q   <= cfg_sel_b;
    end
  end

  assign drv_rst_oe = ~release_q | ~host_rst_n;

  assign soft_hit = cmd_wr && (cmd_byte == SOFT_RST_CODE);

  always_ff @(posedge clk_xtal or negedge rst_chip_n) begin
    if (!rst_chip_n) begin
      pulse_cnt <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= soft_hit;
      if (soft_hit)
        pulse_cnt <= PW'(PULSE_CYCLES);
      else if (pulse_cnt != '0)
        pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  assign cpu_rst_oe = ~rst_chip_n | (pulse_cnt != '0);
  assign cpu_irq    = irq_q;

  always_ff @(posedge clk_xtal or negedge rst_chip_n) begin
    if (!rst_chip_n) div_cnt <= '0;
    else             div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(negedge clk_xtal or negedge rst_chip_n) begin
    if (!rst_chip_n) begin
      mode_a <= SEL_A_RST;
      mode_b <= SEL_B_RST;
    end else begin
      if (div_cnt == '0)              mode_a <= sel_a_q;
      if (div_cnt == DIV_LOG2'(1))    mode_b <= sel_b_q;
    end
  end

  assign mck_a = ((mode_a == 2'b01) & clk_xtal)
               | ((mode_a == 2'b10) & div_cnt[0]);

  assign mck_b = ((mode_b == 2'b01) & clk_xtal)
               | ((mode_b == 2'b10) & ~div_cnt[0])
               | ((mode_b == 2'b11) & div_cnt[DIV_LOG2-1]);

  AST_PULSE_START: assert property (@(posedge clk_xtal) disable iff (!rst_chip_n)
    soft_hit |=> (cpu_rst_oe && cpu_irq)); // R3
  AST_IRQ_SINGLE: assert property (@(posedge clk_xtal) disable iff (!rst_chip_n)
    (cpu_irq && !soft_hit) |=> !cpu_irq); // R4
  AST_PULSE_RANGE: assert property (@(posedge clk_xtal) disable iff (!rst_chip_n)
    pulse_cnt <= PW'(PULSE_CYCLES)); // R5
  AST_PULSE_END: assert property (@(posedge clk_xtal) disable iff (!rst_chip_n)
    ($fell(cpu_rst_oe) && $past(rst_chip_n)) |-> ($past(pulse_cnt) == PW'(1))); // R3
  AST_SWITCH_A: assert property (@(posedge clk_xtal) disable iff (!rst_chip_n)
    (mode_a != $past(mode_a)) |-> (div_cnt == '0)); // R9
  AST_SWITCH_B: assert property (@(posedge clk_xtal) disable iff (!rst_chip_n)
    (mode_b != $past(mode_b)) |-> (div_cnt == DIV_LOG2'(1))); // R9

endmodule

// File: tb/test_rst_clk_unit.sv
module test_rst_clk_unit;
  localparam int P = 50;

  logic       clk_xtal = 1'b0;
  logic       rst_chip_n = 1'b0;
  logic       host_rst_n = 1'b1;
  logic       cfg_we = 1'b0;
  logic       cfg_drv_release = 1'b1;
  logic [1:0] cfg_sel_a = 2'b01;
  logic [1:0] cfg_sel_b = 2'b00;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       drv_rst_oe, cpu_rst_oe, cpu_irq, mck_a, mck_b;

  int checks = 0;
  int fails  = 0;

  rst_clk_unit #(.PULSE_CYCLES(P)) i_rst_clk_unit (
    .clk_xtal(clk_xtal), .rst_chip_n(rst_chip_n), .host_rst_n(host_rst_n),
    .cfg_we(cfg_we), .cfg_drv_release(cfg_drv_release),
    .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b),
    .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .drv_rst_oe(drv_rst_oe), .cpu_rst_oe(cpu_rst_oe), .cpu_irq(cpu_irq),
    .mck_a(mck_a), .mck_b(mck_b)
  );

  always #10 clk_xtal = ~clk_xtal;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_xtal); #5;
  endtask

  task automatic lowhalf();
    @(negedge clk_xtal); #5;
  endtask

  task automatic cfg(input logic rel, input logic [1:0] a, input logic [1:0] b);
    cfg_we = 1'b1; cfg_drv_release = rel; cfg_sel_a = a; cfg_sel_b = b;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] code);
    cmd_wr = 1'b1; cmd_byte = code;
    tick();
    cmd_wr = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic t_reset();
    #3;
    chk(cpu_rst_oe, 1, "R6 oe during chip reset");
    chk(cpu_irq, 0, "R4 irq during reset");
    tick(); tick();
    rst_chip_n = 1'b1;
    tick();
    chk(cpu_rst_oe, 0, "R1 cpu reset released");
    chk(drv_rst_oe, 0, "R1 drive reset released");
    chk(cpu_irq, 0, "R1 irq low");
    chk(mck_a, 1, "R1 mck_a high phase div1");
    chk(mck_b, 0, "R1 mck_b stopped high phase");
    lowhalf();
    chk(mck_a, 0, "R1 mck_a low phase div1");
    chk(mck_b, 0, "R1 mck_b stopped low phase");
  endtask

  task automatic t_drive_reset();
    tick();
    cfg(1'b0, 2'b01, 2'b00);
    chk(drv_rst_oe, 1, "R2 release bit 0");
    host_rst_n = 1'b0; #1;
    chk(drv_rst_oe, 1, "R2 both asserted");
    cfg(1'b1, 2'b01, 2'b00);
    chk(drv_rst_oe, 1, "R2 host low alone");
    host_rst_n = 1'b1; #1;
    chk(drv_rst_oe, 0, "R2 both high floats");
  endtask

  task automatic t_pulse();
    int len = 0;
    cmd(8'h09);
    chk(cpu_rst_oe, 0, "R3 other code ignored");
    chk(cpu_irq, 0, "R4 no irq for other code");
    tick();
    cmd(8'h08);
    chk(cpu_irq, 1, "R4 irq with pulse start");
    while (cpu_rst_oe && len < 4 * P) begin len++; tick(); end
    chk(len, P, "R3 pulse length");
  endtask

  task automatic t_restart();
    int len = 0;
    cmd(8'h08);
    repeat (20) tick();
    cmd(8'h08);
    chk(cpu_irq, 1, "R4 irq on restart");
    tick();
    chk(cpu_irq, 0, "R4 irq one cycle");
    len = 1;
    while (cpu_rst_oe && len < 4 * P) begin len++; tick(); end
    chk(len, P, "R5 restarted pulse length");
  endtask

  task automatic t_chip_reset();
    cfg(1'b0, 2'b00, 2'b00);
    cmd(8'h08);
    repeat (5) tick();
    rst_chip_n = 1'b0; #1;
    chk(cpu_rst_oe, 1, "R6 bypass while low");
    tick();
    rst_chip_n = 1'b1; #1;
    chk(cpu_rst_oe, 0, "R6 pulse cancelled");
    chk(drv_rst_oe, 0, "R1 release bit back to 1");
    tick();
    chk(mck_a, 1, "R1 mck_a back to div1");
  endtask

  task automatic t_clocks();
    int hi = 0;
    int rises = 0;
    logic prev;
    cfg(1'b1, 2'b10, 2'b10);
    repeat (600) tick();
    prev = mck_a;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk(mck_a, !prev, "R7 mck_a half rate toggles");
      chk(mck_b, !mck_a, "R8 mck_b antiphase half rate");
      lowhalf();
      chk(mck_a, !prev, "R7 mck_a stable in low half");
      prev = mck_a;
    end
    cfg(1'b1, 2'b00, 2'b01);
    repeat (600) tick();
    chk(mck_a, 0, "R7 mck_a stopped");
    chk(mck_b, 1, "R8 mck_b div1 high phase");
    lowhalf();
    chk(mck_b, 0, "R8 mck_b div1 low phase");
    cfg(1'b1, 2'b11, 2'b11);
    repeat (600) tick();
    chk(mck_a, 0, "R7 select 11 stopped");
    prev = mck_b;
    for (int i = 0; i < 1024; i++) begin
      tick();
      if (mck_b) hi++;
      if (mck_b && !prev) rises++;
      prev = mck_b;
    end
    chk(hi, 512, "R8 div512 high count");
    chk(rises, 2, "R8 div512 rising edges");
  endtask

  task automatic t_switch();
    int n = 0;
    logic prev;
    cfg(1'b1, 2'b01, 2'b11);
    repeat (600) tick();
    prev = mck_b;
    tick();
    while (!(mck_b && !prev)) begin prev = mck_b; tick(); end
    cfg(1'b1, 2'b00, 2'b11);
    chk(mck_a, 1, "R9 old mode kept after write");
    while (mck_a && n < 700) begin n++; tick(); end
    chk(int'(n > 200 && n < 512), 1, "R9 switch delay in window");
    chk(mck_b, 0, "R9 switch at counter wrap");
    repeat (20) tick();
    chk(mck_a, 0, "R9 stays stopped");
  endtask

  initial begin
    repeat (150000) @(posedge clk_xtal);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_drive_reset();
    t_pulse();
    t_restart();
    t_chip_reset();
    t_clocks();
    t_switch();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule